// File: doc/BRIEF.md
# Audio Sample FIFO with Coded Fill Level

This block is the sample buffer of one audio channel. It stores 32-bit samples in first-in, first-out order and serves either a transmit path or a receive path. The `dir_rx` input selects the path. In transmit mode (`dir_rx` = 0) the bus side pushes samples and the serializer pops them. In receive mode (`dir_rx` = 1) the serializer pushes and the bus side pops.

Besides the stored samples, the block reports three kinds of status. `fill_count` gives the exact occupancy. `level_code` is a 3-bit coarse fill code, and its quarter boundaries are placed differently for each direction. `svc_req` is a request flag that asks the bus side to act: to supply a sample when transmitting, or to collect one when receiving. A synchronous flush empties the buffer in a single cycle.

All status outputs are registered. They change together, one clock after the edge that changed the occupancy. A popped sample appears on `pop_data` one clock after the accepted pop, and `pop_valid` is high in that same cycle. The default depth is 8, so the quarter points are 2, 4 and 6 entries.

Top module: `smp_fifo`

## Requirements
- R1: While `rst` is high and after it is released, `fill_count` is 0, `level_code` is 000 and `pop_valid` is 0. `svc_req` is 1 when `dir_rx` is 0 and 0 when `dir_rx` is 1.
- R2: Samples leave in the order they entered. After an accepted pop, `pop_valid` is 1 in the next cycle and `pop_data` holds the oldest stored sample.
- R3: A push while the FIFO holds DEPTH samples is ignored: the count stays at DEPTH and no stored sample is overwritten. `push_ready` is 0 exactly while the FIFO is full.
- R4: A pop while the FIFO is empty is ignored: the count stays 0 and `pop_valid` stays 0.
- R5: A push and a pop in the same cycle both take effect when the FIFO is neither empty nor full, and the count does not change. When the FIFO is empty only the push takes effect. When it is full only the pop takes effect.
- R6: `fill_count` rises by one per accepted push and falls by one per accepted pop. It changes in the cycle after the edge, in the same cycle as `level_code` and `svc_req`.
- R7: With `dir_rx` = 0 and DEPTH = 8, the `level_code` is 000 at count 0, 001 at counts 1-2, 010 at counts 3-4, 011 at counts 5-6, 100 at count 7 and 101 at count 8 (upper bound of each quarter inclusive).
- R8: With `dir_rx` = 1 and DEPTH = 8, the `level_code` is 000 at count 0, 001 at count 1, 010 at counts 2-3, 011 at counts 4-5, 100 at counts 6-7 and 101 at count 8 (lower bound of each quarter inclusive).
- R9: `level_code` never takes the values 110 or 111.
- R10: `svc_req` is 1 while the FIFO is not full when `dir_rx` = 0, and 1 while it is not empty when `dir_rx` = 1.
- R11: When `flush` is high at an edge, the FIFO becomes empty, whatever push or pop is requested in the same cycle. In the next cycle `fill_count` is 0 and `level_code` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_rx | input | 1 | 0 = transmit mode, 1 = receive mode |
| flush | input | 1 | Synchronous empty request |
| push_en | input | 1 | Push a sample this cycle |
| push_data | input | 32 | Sample to push |
| push_ready | output | 1 | FIFO can accept a push |
| pop_en | input | 1 | Pop a sample this cycle |
| pop_data | output | 32 | Popped sample, valid when pop_valid is 1 |
| pop_valid | output | 1 | pop_data carries the sample of last cycle's accepted pop |
| fill_count | output | 4 | Number of stored samples |
| level_code | output | 3 | Coded fill level |
| svc_req | output | 1 | Service request to the bus side |

## Verification
Three things can land on the same clock edge: a push, a pop and a flush. The stimulus table drives a push and a pop together at full, at empty and at a middle fill, and checks the count, the level code and the request in the next cycle against the R5 rules. One row raises flush together with a push and a pop, and the expected result is an empty FIFO. A directed test then fills the FIFO, offers one extra sample and drains the FIFO. Every popped value is compared with the push order, which shows that the rejected sample neither replaced nor added an entry.

// File: rtl/smp_fifo_pkg.sv
package smp_fifo_pkg;

  typedef enum logic [2:0] {
    LVL_EMPTY = 3'd0,
    LVL_Q1    = 3'd1,
    LVL_Q2    = 3'd2,
    LVL_Q3    = 3'd3,
    LVL_Q4    = 3'd4,
    LVL_FULL  = 3'd5
  } level_e;

  // Coarse fill code. Transmit puts the upper bound of each quarter in
  // that quarter; receive puts the lower bound in it.
  function automatic level_e encode_level(input int unsigned cnt,
                                          input int unsigned depth,
                                          input logic rx);
    int unsigned q;
    q = depth / 4;
    if (cnt == 0)          return LVL_EMPTY;
    else if (cnt >= depth) return LVL_FULL;
    else if (rx) begin
      if (cnt < q)         return LVL_Q1;
      else if (cnt < 2*q)  return LVL_Q2;
      else if (cnt < 3*q)  return LVL_Q3;
      else                 return LVL_Q4;
    end else begin
      if (cnt <= q)        return LVL_Q1;
      else if (cnt <= 2*q) return LVL_Q2;
      else if (cnt <= 3*q) return LVL_Q3;
      else                 return LVL_Q4;
    end
  endfunction

endpackage

// File: rtl/smp_fifo_mem.sv
module smp_fifo_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  // Simple dual-port array with a registered read port, no reset.
  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) rdata <= ram[raddr];
  end

endmodule

// File: rtl/smp_fifo_ptr.sv
module smp_fifo_ptr #(
  parameter int DEPTH = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push_en,
  input  logic              pop_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  count_next,
  output logic              pop_valid_q
);

  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic full, empty;

  assign full  = (count_q == FULL_CNT);
  assign empty = (count_q == '0);

  // A push is judged against full and a pop against empty, both taken from
  // the count before this edge. That is what makes push+pop at full pop only
  // and push+pop at empty push only.
  assign wr_en = push_en && !full  && !flush;
  assign rd_en = pop_en  && !empty && !flush;
  assign wr_addr = wr_ptr;
  assign rd_addr = rd_ptr;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    count_next = count_q;
    if (flush)               count_next = '0;
    else if (wr_en && !rd_en) count_next = count_q + 1'b1;
    else if (rd_en && !wr_en) count_next = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count_q     <= '0;
      pop_valid_q <= 1'b0;
    end else begin
      count_q     <= count_next;
      pop_valid_q <= rd_en;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (wr_en) wr_ptr <= bump(wr_ptr);
        if (rd_en) rd_ptr <= bump(rd_ptr);
      end
    end
  end

  // R3: occupancy never exceeds the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_CNT);

  // R3: push alone at full leaves the count at full
  p_full_push_r3: assert property (@(posedge clk) disable iff (rst)
    (count_q == FULL_CNT && push_en && !pop_en && !flush) |=> count_q == FULL_CNT);

  // R4: pop alone at empty leaves the count at zero and yields no data
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0 && pop_en && !push_en && !flush) |=> (count_q == '0 && !pop_valid_q));

  // R5: push and pop together at a middle fill keep the count
  p_pair_mid_r5: assert property (@(posedge clk) disable iff (rst)
    (push_en && pop_en && !flush && count_q != '0 && count_q != FULL_CNT) |=> $stable(count_q));

  // R6: the count moves by at most one per cycle without flush
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1
                || count_q == $past(count_q) - 1'b1));

  // R11: flush empties the FIFO on the next cycle
  p_flush_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> count_q == '0);

endmodule

// File: rtl/smp_fifo_stat.sv
module smp_fifo_stat
  import smp_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_rx,
  input  logic [CNT_W-1:0] count_next,
  output logic [2:0]       level_q,
  output logic             req_q
);

  level_e lvl_d;
  logic   req_d;

  always_comb begin
    lvl_d = encode_level(32'(count_next), DEPTH, dir_rx);
    if (dir_rx) req_d = (count_next != '0);
    else        req_d = (count_next != CNT_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= LVL_EMPTY;
      req_q   <= !dir_rx;
    end else begin
      level_q <= lvl_d;
      req_q   <= req_d;
    end
  end

  // R9: reserved codes are never produced
  p_no_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    level_q != 3'd6 && level_q != 3'd7);

endmodule

// File: rtl/smp_fifo.sv
module smp_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_rx,
  input  logic              flush,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  input  logic              pop_en,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic [CNT_W-1:0]  fill_count,
  output logic [2:0]        level_code,
  output logic              svc_req
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0]  count_next;

  smp_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .push_en    (push_en),
    .pop_en     (pop_en),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .count_q    (fill_count),
    .count_next (count_next),
    .pop_valid_q(pop_valid)
  );

  smp_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (push_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (pop_data)
  );

  smp_fifo_stat #(.DEPTH(DEPTH)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .dir_rx     (dir_rx),
    .count_next (count_next),
    .level_q    (level_code),
    .req_q      (svc_req)
  );

  assign push_ready = (fill_count != FULL_CNT);

  // R2: valid data only follows a pop that found data and no flush
  p_pop_valid_r2: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> $past(pop_en && fill_count != '0 && !flush));

  // R7: an empty FIFO reports code 000
  p_empty_level_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_count == '0) |-> level_code == 3'd0);

  // R8: a full FIFO reports code 101
  p_full_level_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_count == FULL_CNT) |-> level_code == 3'd5);

  // R10: no receive request while empty, no transmit request while full
  p_req_dir_r10: assert property (@(posedge clk) disable iff (rst)
    ((fill_count == '0 && $past(dir_rx)) || (fill_count == FULL_CNT && !$past(dir_rx)))
      |-> !svc_req);

endmodule

// File: tb/smp_fifo_test.sv
module smp_fifo_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  logic        clk = 1'b0;
  logic        rst;
  logic        dir_rx, flush, push_en, pop_en;
  logic [31:0] push_data;
  logic        push_ready, pop_valid, svc_req;
  logic [31:0] pop_data;
  logic [3:0]  fill_count;
  logic [2:0]  level_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  smp_fifo uut (
    .clk(clk), .rst(rst), .dir_rx(dir_rx), .flush(flush),
    .push_en(push_en), .push_data(push_data), .push_ready(push_ready),
    .pop_en(pop_en), .pop_data(pop_data), .pop_valid(pop_valid),
    .fill_count(fill_count), .level_code(level_code), .svc_req(svc_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Fields: [11] push, [10] pop, [9] flush, [8] dir_rx,
  //         [7:4] expected count, [3:1] expected level, [0] expected request
  localparam logic [11:0] TBL [NVEC] = '{
    12'b1000_0001_001_1, // 0  tx push -> 1, R7
    12'b1000_0010_001_1, // 1  2: quarter bound inclusive
    12'b1000_0011_010_1, // 2
    12'b1000_0100_010_1, // 3
    12'b1000_0101_011_1, // 4
    12'b1000_0110_011_1, // 5
    12'b1000_0111_100_1, // 6
    12'b1000_1000_101_0, // 7  full, no tx request
    12'b1000_1000_101_0, // 8  push at full ignored (R3)
    12'b1100_0111_100_1, // 9  push+pop at full: pop only (R5)
    12'b0001_0111_100_1, // 10 switch to rx (R8)
    12'b0101_0110_100_1, // 11 6 -> 100 in rx
    12'b0101_0101_011_1, // 12
    12'b0101_0100_011_1, // 13
    12'b0101_0011_010_1, // 14
    12'b1101_0011_010_1, // 15 push+pop mid: count kept (R5)
    12'b0101_0010_010_1, // 16
    12'b0101_0001_001_1, // 17
    12'b0101_0000_000_0, // 18 empty, no rx request
    12'b0101_0000_000_0, // 19 pop at empty ignored (R4)
    12'b1101_0001_001_1, // 20 push+pop at empty: push only (R5)
    12'b1001_0010_010_1, // 21
    12'b0000_0010_001_1, // 22 back to tx: 2 -> 001
    12'b1000_0011_010_1, // 23
    12'b1110_0000_000_1, // 24 flush beats push and pop (R11)
    12'b0001_0000_000_0, // 25
    12'b1001_0001_001_1  // 26
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next
  // falling edge with the strobes released.
  task automatic step(input logic pu, input logic po, input logic fl,
                      input logic dr, input logic [31:0] d);
    push_en = pu; pop_en = po; flush = fl; dir_rx = dr; push_data = d;
    @(posedge clk);
    @(negedge clk);
    push_en = 1'b0; pop_en = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; dir_rx = 1'b0; flush = 1'b0;
    push_en = 1'b0; pop_en = 1'b0; push_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, transmit direction
    check("R1 count in reset", int'(fill_count), 0);
    check("R1 level in reset", int'(level_code), 0);
    check("R1 tx request in reset", int'(svc_req), 1);
    check("R1 pop_valid in reset", int'(pop_valid), 0);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b0, '0);
    check("R1 count after reset", int'(fill_count), 0);
    check("R1 ready after reset", int'(push_ready), 1);

    // Table walk: R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      step(TBL[i][11], TBL[i][10], TBL[i][9], TBL[i][8], 32'hA000_0000 + i);
      check($sformatf("R6 count row %0d", i), int'(fill_count), int'(TBL[i][7:4]));
      check($sformatf("R7/R8 level row %0d", i), int'(level_code), int'(TBL[i][3:1]));
      check($sformatf("R10 request row %0d", i), int'(svc_req), int'(TBL[i][0]));
      check($sformatf("R9 no reserved row %0d", i), int'(level_code <= 3'd5), 1);
    end

    // R11: flush, then fill with distinct samples in transmit mode
    step(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R11 count after flush", int'(fill_count), 0);
    check("R11 level after flush", int'(level_code), 0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 32'h5A00_0010 + i);
    check("R3 ready low when full", int'(push_ready), 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
    check("R3 count after push at full", int'(fill_count), 8);

    // R2/R3: drain and compare order; the rejected sample must not appear
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, '0);
      check($sformatf("R2 pop_valid %0d", i), int'(pop_valid), 1);
      check($sformatf("R2 R3 pop_data %0d", i), int'(pop_data), int'(32'h5A00_0010 + i));
    end
    check("R6 count after drain", int'(fill_count), 0);

    // R4: pop at empty gives nothing
    step(1'b0, 1'b1, 1'b0, 1'b0, '0);
    check("R4 pop_valid at empty", int'(pop_valid), 0);
    check("R4 count at empty", int'(fill_count), 0);

    // R2: interleaved push+pop at a middle fill keeps order
    step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0111);
    step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0222);
    step(1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0333);
    check("R2 first out on pair", int'(pop_data), 32'h111);
    check("R5 count on pair", int'(fill_count), 2);
    step(1'b0, 1'b1, 1'b0, 1'b1, '0);
    check("R2 second out", int'(pop_data), 32'h222);
    step(1'b0, 1'b1, 1'b0, 1'b1, '0);
    check("R2 third out", int'(pop_data), 32'h333);

    // R1: reset in mid-operation, receive direction
    step(1'b1, 1'b0, 1'b0, 1'b1, 32'h1);
    step(1'b1, 1'b0, 1'b0, 1'b1, 32'h2);
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b1, '0);
    check("R1 count on reset", int'(fill_count), 0);
    check("R1 level on reset", int'(level_code), 0);
    check("R1 rx request on reset", int'(svc_req), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule